// File: doc/BRIEF.md
# UV-Erasable Programmable Memory Mode Controller

This block is a clocked, synthesizable model of a byte-wide, ultraviolet-erasable programmable read-only memory and the logic that decodes its operating modes. It samples two active-low enables, a 19-bit address and the incoming data byte on every rising clock edge. The two high-voltage conditions are represented as plain digital flags: one for a raised programming supply and one for the signature voltage on address bit 9.

From these inputs it selects one of the following modes:

- normal read
- output disable
- standby
- program
- program inhibit
- verify
- identifier (signature) read

It either drives a byte onto the data bus or releases the bus. The release is shown by a low output-enable flag, `dq_oe`.

Programming is one-directional. A program pulse can only clear bits, so the stored byte becomes the old byte ANDed with the bus data. Only the synchronous `erase` input, which stands in for ultraviolet exposure, returns the whole array to all ones. The array is parameterised to a small depth for simulation. The full 19-bit address is still decoded: a location at or above the implemented depth reads as an erased byte and cannot be programmed.

Top module: `uvprom_ctrl`

## Requirements
- R1: After reset the bus is released (`dq_oe` = 0) and every location reads 8'hFF.
- R2: With `vpp_hi` = 0, `sig_hv` = 0, `ce_n` = 0 and `oe_n` = 0 sampled at a rising edge, `dq_oe` = 1 and `dq_o` holds the byte at `addr` from that edge until the next one.
- R3: With `ce_n` = 0 and `oe_n` = 1 while `vpp_hi` = 0, the bus is released.
- R4: With `ce_n` = 1 while `vpp_hi` = 0, the bus is released whatever the value of `oe_n`.
- R5: With `vpp_hi` = 1 and `oe_n` = 1, the edge where `ce_n` is first sampled low after having been sampled high stores (old AND `dq_i`) at `addr`. Later edges within the same low pulse write nothing.
- R6: A low pulse on `ce_n` while `vpp_hi` = 0 changes no stored byte.
- R7: With `vpp_hi` = 1, `ce_n` = 1 and `oe_n` = 0, the block drives the stored byte at `addr` (verify).
- R8: With `vpp_hi` = 1 and both enables high, the bus is released and nothing is stored.
- R9: `erase` = 1 at an edge sets every location to 8'hFF. If a program pulse starts at the same edge, the erase wins.
- R10: With `sig_hv` = 1 in a read (`vpp_hi` = 0, both enables low), `dq_o` is 8'h97 when `addr[0]` = 0 and 8'h50 when `addr[0]` = 1. The array is not altered.
- R11: An address at or above the implemented depth reads 8'hFF, and a program pulse to it changes nothing.
- R12: With `vpp_hi` = 1 and both enables low, the bus is released and a falling `ce_n` stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; array starts erased |
| ce_n | input | 1 | Active-low chip enable; program pulse line |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply raised |
| sig_hv | input | 1 | Signature voltage present on address bit 9 |
| erase | input | 1 | Synchronous whole-array erase |
| addr | input | 19 | Byte address |
| dq_i | input | 8 | Data bus value seen by the block |
| dq_o | output | 8 | Data the block drives |
| dq_oe | output | 1 | 1 = block drives the bus, 0 = high impedance |

## Verification
An erase and the leading edge of a program pulse can land on the same clock edge. They then compete for the same array storage. The bench starts a program pulse to a location holding a programmed byte while `erase` is high at that very edge. Afterwards it reads back both the addressed location and an unrelated programmed one: both must read 8'hFF. A second pairing, where a falling `ce_n` coincides with a low `oe_n` under raised supply, is judged by a released bus and an unchanged verify readback.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

    typedef enum logic [2:0] {
        M_STANDBY  = 3'd0,
        M_READ     = 3'd1,
        M_IDENT    = 3'd2,
        M_OUTOFF   = 3'd3,
        M_PROG     = 3'd4,
        M_VERIFY   = 3'd5,
        M_INHIBIT  = 3'd6,
        M_CLASH    = 3'd7
    } mode_e;

    localparam logic [7:0] MAKER_ID  = 8'h97;
    localparam logic [7:0] PART_ID   = 8'h50;

endpackage

// File: rtl/uvprom_decode.sv
module uvprom_decode
    import uvprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  sig_hv,
    output mode_e mode
);

    always_comb begin
        mode = M_STANDBY;
        if (vpp_hi) begin
            unique case ({ce_n, oe_n})
                2'b01:   mode = M_PROG;
                2'b10:   mode = M_VERIFY;
                2'b11:   mode = M_INHIBIT;
                default: mode = M_CLASH;
            endcase
        end else begin
            unique case ({ce_n, oe_n})
                2'b00:   mode = sig_hv ? M_IDENT : M_READ;
                2'b01:   mode = M_OUTOFF;
                default: mode = M_STANDBY;
            endcase
        end
    end

endmodule

// File: rtl/uvprom_array.sv
module uvprom_array #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = ({1'b0, addr} < (ADDR_W+1)'(DEPTH));
    assign idx      = addr[IDX_W-1:0];
    assign rdata    = in_range ? mem_q[idx] : BLANK;

    always_comb begin
        mem_d = mem_q;
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = BLANK;
        end else if (wr_en && in_range) begin
            mem_d[idx] = mem_q[idx] & wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R5
    only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(erase) |-> ((mem_q[0] & ~$past(mem_q[0])) == '0));

    // R9
    erase_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(erase) |-> (mem_q[DEPTH-1] == BLANK));

endmodule

// File: rtl/uvprom_ctrl.sv
module uvprom_ctrl
    import uvprom_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    parameter logic [DATA_W-1:0] MAKER_CODE = DATA_W'(MAKER_ID),
    parameter logic [DATA_W-1:0] PART_CODE  = DATA_W'(PART_ID)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              sig_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    typedef struct packed {
        logic              ce_prev;
        logic              drive;
        logic [DATA_W-1:0] dout;
    } ctl_t;

    ctl_t              st_d, st_q;
    mode_e             mode;
    logic              wr_en;
    logic [DATA_W-1:0] rd_byte;

    uvprom_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .sig_hv (sig_hv),
        .mode   (mode)
    );

    uvprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .erase  (erase),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (dq_i),
        .rdata  (rd_byte)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ce_prev = ce_n;
        st_d.drive   = 1'b0;
        st_d.dout    = '0;
        wr_en        = (mode == M_PROG) && st_q.ce_prev;
        case (mode)
            M_READ, M_VERIFY: begin
                st_d.drive = 1'b1;
                st_d.dout  = rd_byte;
            end
            M_IDENT: begin
                st_d.drive = 1'b1;
                st_d.dout  = addr[0] ? PART_CODE : MAKER_CODE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ce_prev: 1'b1, drive: 1'b0, dout: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o  = st_q.dout;
    assign dq_oe = st_q.drive;

    // R3
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(oe_n));

    // R4
    standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !$past(vpp_hi)) |-> !$past(ce_n));

    // R12
    clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !($past(vpp_hi) && !$past(ce_n)));

    // R10
    ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(sig_hv) && !$past(vpp_hi)) |->
            (dq_o == ($past(addr[0]) ? PART_CODE : MAKER_CODE)));

endmodule

// File: tb/uvprom_ctrl_test.sv
module uvprom_ctrl_test;

    localparam int AW = 19;
    localparam int DW = 8;
    localparam int DP = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, sig_hv = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [DW-1:0] model [DP];

    always #10 clk = ~clk;

    uvprom_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .sig_hv(sig_hv), .erase(erase), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; sig_hv = 1'b0; erase = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] exp_at(input logic [AW-1:0] a);
        return (a < AW'(DP)) ? model[a[7:0]] : 8'hFF;
    endfunction

    task automatic read_chk(input logic [AW-1:0] a, input string req);
        addr = a; vpp_hi = 1'b0; sig_hv = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk(dq_oe == 1'b1 && dq_o == exp_at(a), req, {dq_oe, dq_o}, {1'b1, exp_at(a)});
        go_idle();
    endtask

    task automatic verify_chk(input logic [AW-1:0] a, input string req);
        addr = a; vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk(dq_oe == 1'b1 && dq_o == exp_at(a), req, {dq_oe, dq_o}, {1'b1, exp_at(a)});
        go_idle();
    endtask

    task automatic prog_pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic supply);
        addr = a; dq_i = d; vpp_hi = supply; oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        if (supply && a < AW'(DP)) model[a[7:0]] = model[a[7:0]] & d;
        go_idle();
    endtask

    task automatic t_reset();
        chk(dq_oe == 1'b0, "R1 bus after reset", {1'b0, dq_oe}, 9'h0);
        read_chk(19'd0, "R1 erased loc 0");
        read_chk(19'd255, "R1 erased loc 255");
    endtask

    task automatic t_program();
        prog_pulse(19'd5, 8'hA5, 1'b1);
        read_chk(19'd5, "R5 first program / R2 read");
        prog_pulse(19'd5, 8'h0F, 1'b1);
        read_chk(19'd5, "R5 AND with old");
        prog_pulse(19'd5, 8'hFF, 1'b1);
        read_chk(19'd5, "R5 ones cannot be set");
        prog_pulse(19'd77, 8'h3C, 1'b1);
        read_chk(19'd77, "R2 second location");
        read_chk(19'd5, "R2 neighbour intact");
    endtask

    task automatic t_held_low();
        addr = 19'd20; dq_i = 8'hF0; vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        dq_i = 8'h0F;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        model[20] = model[20] & 8'hF0;
        verify_chk(19'd20, "R5 one write per pulse / R7 verify");
    endtask

    task automatic t_no_supply();
        addr = 19'd30; dq_i = 8'h00; vpp_hi = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R3 output disable", {1'b0, dq_oe}, 9'h0);
        go_idle();
        read_chk(19'd30, "R6 pulse without supply ignored");
    endtask

    task automatic t_standby();
        addr = 19'd5; vpp_hi = 1'b0; ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R4 standby oe low", {1'b0, dq_oe}, 9'h0);
        oe_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R4 standby oe high", {1'b0, dq_oe}, 9'h0);
        go_idle();
    endtask

    task automatic t_inhibit();
        addr = 19'd40; dq_i = 8'h00; vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0, "R8 inhibit released", {1'b0, dq_oe}, 9'h0);
        go_idle();
        verify_chk(19'd40, "R8 inhibit stores nothing");
    endtask

    task automatic t_clash();
        addr = 19'd77; dq_i = 8'h00; vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R12 both low under supply released", {1'b0, dq_oe}, 9'h0);
        go_idle();
        verify_chk(19'd77, "R12 no write");
    endtask

    task automatic t_ident();
        addr = 19'd0; vpp_hi = 1'b0; sig_hv = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk(dq_oe && dq_o == 8'h97, "R10 maker id", {dq_oe, dq_o}, 9'h197);
        addr = 19'd1;
        @(negedge clk);
        chk(dq_oe && dq_o == 8'h50, "R10 part id", {dq_oe, dq_o}, 9'h150);
        go_idle();
        read_chk(19'd0, "R10 array untouched loc 0");
        read_chk(19'd1, "R10 array untouched loc 1");
    endtask

    task automatic t_range();
        prog_pulse(19'h40005, 8'h00, 1'b1);
        read_chk(19'h40005, "R11 out of range reads blank");
        read_chk(19'd5, "R11 alias not written");
        prog_pulse(19'd256, 8'h00, 1'b1);
        read_chk(19'd0, "R11 first outside no alias");
    endtask

    task automatic t_erase();
        prog_pulse(19'd9, 8'h12, 1'b1);
        read_chk(19'd9, "R5 pre-erase program");
        addr = 19'd9; dq_i = 8'h00; vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; erase = 1'b1;
        @(negedge clk);
        erase = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < DP; i++) model[i] = 8'hFF;
        go_idle();
        read_chk(19'd9, "R9 erase beats program");
        read_chk(19'd5, "R9 other location erased");
        read_chk(19'd77, "R9 third location erased");
    endtask

    initial begin
        for (int i = 0; i < DP; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_held_low();
        t_no_supply();
        t_standby();
        t_inhibit();
        t_clash();
        t_ident();
        t_range();
        t_erase();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule